// File: doc/BRIEF.md
# Directory Home Controller for Coherent Shared Memory

This block is the home side of a directory-based coherence scheme. It sits beside a small local memory array and keeps one directory entry per block. Each entry holds a coherence state (uncached, shared or exclusive) and a presence vector with one bit per node. Nodes in the system send read misses, write misses and write-backs to the home. The home answers with point-to-point messages: memory data to the requester, invalidations to the current sharers, and fetch requests to the exclusive owner. The remote nodes answer invalidations with acknowledgements and answer fetches with the dirty data.

A single transaction engine serialises the work. A read miss or write miss that needs no remote action completes in one cycle. A miss that needs invalidations or a fetch holds the request channel not-ready until its final data reply has been sent.

Top module: `dirh_home`

## Requirements
- R1: After reset every block is uncached with memory contents zero. `req_ready` is high and `msg_valid` is low.
- R2: A read miss (`req_kind`=0) to an uncached or shared block produces one data message (`msg_kind`=0) to the requester carrying the memory value. The requester is then recorded as a sharer.
- R3: A write miss (`req_kind`=1) to a shared block with sharers other than the requester sends one invalidate (`msg_kind`=1) to each of those sharers, in ascending node order and one per cycle. The requester is never invalidated. The data reply follows only after an acknowledgement (`rsp_kind`=0) for that block has arrived for every invalidate. The requester becomes sole exclusive owner.
- R4: A write miss to an uncached block, or to a shared block whose only sharer is the requester, replies with memory data at once and makes the requester the exclusive owner.
- R5: A read miss to an exclusive block sends a fetch (`msg_kind`=2) to the owner. The data response (`rsp_kind`=1) from that owner for that block is written to memory and forwarded to the requester. Owner and requester are both left as sharers.
- R6: A write miss to an exclusive block fetches from the owner, updates memory, forwards the data, and makes the requester the new sole owner.
- R7: A write-back (`req_kind`=2) from the exclusive owner stores `req_data` in memory and returns the block to uncached with an empty sharer vector. It produces no message.
- R8: A write-back from a node that is not the exclusive owner of the block changes neither memory nor the directory entry.
- R9: While an invalidate or fetch transaction is pending, `req_ready` stays low. Responses for other blocks, or fetch data from a node other than the owner, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Home can accept a request this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | NODE_W | Requesting node |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch |
| msg_node | output | NODE_W | Target node |
| msg_blk | output | BLK_W | Block index |
| msg_data | output | DATA_W | Data for data replies, zero otherwise |
| rsp_valid | input | 1 | Remote response present |
| rsp_kind | input | 1 | 0 invalidate acknowledgement, 1 fetch data |
| rsp_node | input | NODE_W | Responding node |
| rsp_blk | input | BLK_W | Block index |
| rsp_data | input | DATA_W | Fetched data |

## Verification
A corrupted presence vector shows up on the very next write miss to that block: either the set of invalidate targets is wrong or an invalidate is missing. A corrupted state shows up on the next read miss, which answers from memory when it should fetch, or fetches when it should answer from memory. A lost memory update shows up as a wrong data value in the next reply. The bench therefore follows each mutation with a later access that exposes it. It compares every message against the reference model's queue in the cycle the message appears.

// File: rtl/dirh_pkg.sv
package dirh_pkg;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_DATA  = 2'd0,
        MS_INV   = 2'd1,
        MS_FETCH = 2'd2
    } msg_kind_e;

    typedef enum logic [1:0] {
        BS_UNC = 2'd0,
        BS_SHR = 2'd1,
        BS_EXC = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_INV   = 2'd1,
        CT_ACK   = 2'd2,
        CT_FETCH = 2'd3
    } ctl_state_e;

    localparam logic RSP_ACK  = 1'b0;
    localparam logic RSP_DATA = 1'b1;

endpackage

// File: rtl/dirh_first.sv
module dirh_first #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dirh_table.sv
module dirh_table
    import dirh_pkg::*;
#(
    parameter int BLOCKS = 4,
    parameter int NODES  = 8,
    parameter int DATA_W = 16,
    localparam int BLK_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  rd_blk,
    output blk_state_e        rd_state,
    output logic [NODES-1:0]  rd_sh,
    output logic [DATA_W-1:0] rd_mem,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_blk,
    input  blk_state_e        wr_state,
    input  logic [NODES-1:0]  wr_sh,
    input  logic              wr_mem_en,
    input  logic [DATA_W-1:0] wr_mem
);
    blk_state_e        st_q  [BLOCKS];
    logic [NODES-1:0]  sh_q  [BLOCKS];
    logic [DATA_W-1:0] mem_q [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        logic hit;
        assign hit = (wr_blk == BLK_W'(b));
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[b]  <= BS_UNC;
                sh_q[b]  <= '0;
                mem_q[b] <= '0;
            end else begin
                if (wr_en && hit) begin
                    st_q[b] <= wr_state;
                    sh_q[b] <= wr_sh;
                end
                if (wr_mem_en && hit) mem_q[b] <= wr_mem;
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_sh    = sh_q[rd_blk];
    assign rd_mem   = mem_q[rd_blk];
endmodule

// File: rtl/dirh_home.sv
module dirh_home
    import dirh_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int BLOCKS = 4,
    parameter int DATA_W = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int BLK_W  = $clog2(BLOCKS),
    localparam int CNT_W  = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [NODE_W-1:0] msg_node,
    output logic [BLK_W-1:0]  msg_blk,
    output logic [DATA_W-1:0] msg_data,
    input  logic              rsp_valid,
    input  logic              rsp_kind,
    input  logic [NODE_W-1:0] rsp_node,
    input  logic [BLK_W-1:0]  rsp_blk,
    input  logic [DATA_W-1:0] rsp_data
);
    ctl_state_e        ctl_q;
    logic [NODE_W-1:0] t_node, owner_q;
    logic [BLK_W-1:0]  t_blk;
    logic              t_is_rd;
    logic [NODES-1:0]  pend_q;
    logic [CNT_W-1:0]  need_q, got_q;

    logic [BLK_W-1:0]  rd_blk;
    blk_state_e        rd_state;
    logic [NODES-1:0]  rd_sh;
    logic [DATA_W-1:0] rd_mem;
    logic              tw_en, tw_mem_en;
    blk_state_e        tw_state;
    logic [NODES-1:0]  tw_sh;
    logic [DATA_W-1:0] tw_mem;

    logic [NODES-1:0]  req_bit, t_bit, others, nxt_bit;
    logic [CNT_W-1:0]  others_cnt;
    logic              own_any, pend_any;
    logic [NODE_W-1:0] own_idx, nxt_idx;
    logic              ack_hit, fetch_hit, acks_all, go_fetch;
    req_kind_e         rk;

    assign req_ready = (ctl_q == CT_IDLE);
    assign rd_blk    = req_ready ? req_blk : t_blk;
    assign rk        = req_kind_e'(req_kind);
    assign req_bit   = NODES'(1) << req_node;
    assign t_bit     = NODES'(1) << t_node;
    assign others    = rd_sh & ~req_bit;
    assign nxt_bit   = NODES'(1) << nxt_idx;
    assign go_fetch  = (rd_state == BS_EXC) && own_any;
    assign ack_hit   = rsp_valid && (rsp_kind == RSP_ACK) && (rsp_blk == t_blk);
    assign fetch_hit = rsp_valid && (rsp_kind == RSP_DATA) && (rsp_blk == t_blk)
                       && (rsp_node == owner_q);
    assign acks_all  = (got_q == need_q);

    dirh_table #(.BLOCKS(BLOCKS), .NODES(NODES), .DATA_W(DATA_W)) u_tab (
        .clk(clk), .rst(rst), .rd_blk(rd_blk), .rd_state(rd_state), .rd_sh(rd_sh),
        .rd_mem(rd_mem), .wr_en(tw_en), .wr_blk(rd_blk), .wr_state(tw_state),
        .wr_sh(tw_sh), .wr_mem_en(tw_mem_en), .wr_mem(tw_mem)
    );

    dirh_first #(.W(NODES)) u_own (.vec(rd_sh),  .any(own_any),  .idx(own_idx));
    dirh_first #(.W(NODES)) u_nxt (.vec(pend_q), .any(pend_any), .idx(nxt_idx));

    always_comb begin
        others_cnt = '0;
        for (int i = 0; i < NODES; i++) others_cnt = others_cnt + CNT_W'(others[i]);
    end

    // directory update decisions
    always_comb begin
        tw_en     = 1'b0;
        tw_state  = rd_state;
        tw_sh     = rd_sh;
        tw_mem_en = 1'b0;
        tw_mem    = req_data;
        unique case (ctl_q)
            CT_IDLE: if (req_valid) begin
                if (rk == RQ_READ && !go_fetch) begin
                    tw_en = 1'b1; tw_state = BS_SHR; tw_sh = rd_sh | req_bit;
                end else if (rk == RQ_WRITE && !go_fetch && others == '0) begin
                    tw_en = 1'b1; tw_state = BS_EXC; tw_sh = req_bit;
                end else if (rk == RQ_WBACK && rd_state == BS_EXC && rd_sh[req_node]) begin
                    tw_en = 1'b1; tw_state = BS_UNC; tw_sh = '0; tw_mem_en = 1'b1;
                end
            end
            CT_ACK: if (acks_all) begin
                tw_en = 1'b1; tw_state = BS_EXC; tw_sh = t_bit;
            end
            CT_FETCH: if (fetch_hit) begin
                tw_en = 1'b1; tw_mem_en = 1'b1; tw_mem = rsp_data;
                if (t_is_rd) begin
                    tw_state = BS_SHR; tw_sh = t_bit | (NODES'(1) << owner_q);
                end else begin
                    tw_state = BS_EXC; tw_sh = t_bit;
                end
            end
            default: ;
        endcase
    end

    // transaction engine and message register
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= CT_IDLE;
            t_node    <= '0;
            t_blk     <= '0;
            t_is_rd   <= 1'b0;
            owner_q   <= '0;
            pend_q    <= '0;
            need_q    <= '0;
            got_q     <= '0;
            msg_valid <= 1'b0;
            msg_kind  <= MS_DATA;
            msg_node  <= '0;
            msg_blk   <= '0;
            msg_data  <= '0;
        end else begin
            msg_valid <= 1'b0;
            msg_data  <= '0;
            unique case (ctl_q)
                CT_IDLE: if (req_valid) begin
                    t_node  <= req_node;
                    t_blk   <= req_blk;
                    t_is_rd <= (rk == RQ_READ);
                    msg_blk <= req_blk;
                    if (rk != RQ_WBACK) begin
                        msg_valid <= 1'b1;
                        if (go_fetch) begin
                            ctl_q    <= CT_FETCH;
                            owner_q  <= own_idx;
                            msg_kind <= MS_FETCH;
                            msg_node <= own_idx;
                        end else if (rk == RQ_WRITE && others != '0) begin
                            msg_valid <= 1'b0;
                            ctl_q     <= CT_INV;
                            pend_q    <= others;
                            need_q    <= others_cnt;
                            got_q     <= '0;
                        end else begin
                            msg_kind <= MS_DATA;
                            msg_node <= req_node;
                            msg_data <= rd_mem;
                        end
                    end
                end
                CT_INV: begin
                    if (pend_any) begin
                        msg_valid <= 1'b1;
                        msg_kind  <= MS_INV;
                        msg_node  <= nxt_idx;
                        msg_blk   <= t_blk;
                    end
                    pend_q <= pend_q & ~nxt_bit;
                    if ((pend_q & ~nxt_bit) == '0) ctl_q <= CT_ACK;
                    if (ack_hit) got_q <= got_q + 1'b1;
                end
                CT_ACK: begin
                    if (acks_all) begin
                        ctl_q     <= CT_IDLE;
                        msg_valid <= 1'b1;
                        msg_kind  <= MS_DATA;
                        msg_node  <= t_node;
                        msg_blk   <= t_blk;
                        msg_data  <= rd_mem;
                    end else if (ack_hit) begin
                        got_q <= got_q + 1'b1;
                    end
                end
                CT_FETCH: if (fetch_hit) begin
                    ctl_q     <= CT_IDLE;
                    msg_valid <= 1'b1;
                    msg_kind  <= MS_DATA;
                    msg_node  <= t_node;
                    msg_blk   <= t_blk;
                    msg_data  <= rsp_data;
                end
                default: ctl_q <= CT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dirh_home_chk.sv
module dirh_home_chk
    import dirh_pkg::*;
#(
    parameter int NODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic              msg_valid,
    input logic [1:0]        msg_kind,
    input logic [NODE_W-1:0] msg_node,
    input logic [NODE_W-1:0] t_node
);
    a_r2_data_frees_engine: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_DATA) |-> req_ready);

    a_r3_inv_skips_requester: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INV) |-> (msg_node != t_node));

    a_r5_fetch_holds_channel: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_FETCH) |-> !req_ready);

    a_r7_wback_silent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == RQ_WBACK) |=> !msg_valid);

    a_r9_inv_holds_channel: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INV) |-> !req_ready);
endmodule

bind dirh_home dirh_home_chk #(.NODE_W(NODE_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_node(msg_node), .t_node(t_node)
);

// File: tb/sim_dirh_home.sv
`timescale 1ns/1ps
module sim_dirh_home;
    localparam int NODES = 8, BLOCKS = 4, DW = 16;

    logic clk = 0;
    logic rst = 1;
    always #2.5 clk = ~clk;

    logic          req_valid = 0;
    logic          req_ready;
    logic [1:0]    req_kind = 0;
    logic [2:0]    req_node = 0;
    logic [1:0]    req_blk = 0;
    logic [DW-1:0] req_data = 0;
    logic          msg_valid;
    logic [1:0]    msg_kind;
    logic [2:0]    msg_node;
    logic [1:0]    msg_blk;
    logic [DW-1:0] msg_data;
    logic          rsp_valid = 0;
    logic          rsp_kind = 0;
    logic [2:0]    rsp_node = 0;
    logic [1:0]    rsp_blk = 0;
    logic [DW-1:0] rsp_data = 0;

    dirh_home u0 (.*);

    typedef struct {
        int k; int node; int blk; logic [DW-1:0] d; string tag;
    } ev_t;

    ev_t exp_q[$];
    ev_t rsp_q[$];
    ev_t inj_q[$];
    int  checks = 0, fails = 0, gen = 0;
    bit  hold = 0;

    // reference model state
    int            m_st [BLOCKS];
    bit [7:0]      m_sh [BLOCKS];
    logic [DW-1:0] m_mem [BLOCKS];

    function automatic logic [DW-1:0] fdata(int n, int b);
        return 16'hC000 | (16'(gen % 16) << 8) | (16'(n) << 4) | 16'(b);
    endfunction

    function automatic int first_bit(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic void push(int k, int n, int b, logic [DW-1:0] d, string tag);
        ev_t e;
        e.k = k; e.node = n; e.blk = b; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    // model: 0 uncached, 1 shared, 2 exclusive
    function automatic void model_accept(int k, int n, int b, logic [DW-1:0] d);
        bit [7:0] others;
        int o;
        if (k == 0) begin
            if (m_st[b] == 2) begin
                o = first_bit(m_sh[b]);
                push(2, o, b, '0, "R5");
                m_mem[b] = fdata(o, b);
                push(0, n, b, m_mem[b], "R5");
                m_sh[b] = (8'd1 << o) | (8'd1 << n);
            end else begin
                push(0, n, b, m_mem[b], "R2");
                m_sh[b] = m_sh[b] | (8'd1 << n);
            end
            m_st[b] = 1;
        end else if (k == 1) begin
            others = m_sh[b] & ~(8'd1 << n);
            if (m_st[b] == 2) begin
                o = first_bit(m_sh[b]);
                push(2, o, b, '0, "R6");
                m_mem[b] = fdata(o, b);
                push(0, n, b, m_mem[b], "R6");
            end else if (m_st[b] == 1 && others != 0) begin
                for (int i = 0; i < 8; i++) if (others[i]) push(1, i, b, '0, "R3");
                push(0, n, b, m_mem[b], "R3");
            end else begin
                push(0, n, b, m_mem[b], "R4");
            end
            m_sh[b] = 8'd1 << n;
            m_st[b] = 2;
        end else begin
            if (m_st[b] == 2 && m_sh[b][n]) begin
                m_mem[b] = d; m_sh[b] = 0; m_st[b] = 0;
            end
        end
    endfunction

    // responder and message monitor, one process per negative edge
    always @(negedge clk) begin
        if (!rst) begin
            ev_t r, e;
            rsp_valid = 0;
            if (inj_q.size() > 0) begin
                r = inj_q.pop_front();
                rsp_valid = 1; rsp_kind = r.k[0]; rsp_node = 3'(r.node);
                rsp_blk = 2'(r.blk); rsp_data = r.d;
            end else if (!hold && rsp_q.size() > 0) begin
                r = rsp_q.pop_front();
                rsp_valid = 1; rsp_kind = r.k[0]; rsp_node = 3'(r.node);
                rsp_blk = 2'(r.blk); rsp_data = r.d;
            end
            if (msg_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected message", int'(msg_kind), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(int'(msg_kind) == e.k && int'(msg_node) == e.node &&
                        int'(msg_blk) == e.blk && msg_data == e.d,
                        e.tag, {msg_kind, msg_node, msg_blk, msg_data},
                        {e.k[1:0], e.node[2:0], e.blk[1:0], e.d});
                end
                if (msg_kind == 2'd1) begin
                    r.k = 0; r.node = int'(msg_node); r.blk = int'(msg_blk); r.d = '0;
                    rsp_q.push_back(r);
                end else if (msg_kind == 2'd2) begin
                    r.k = 1; r.node = int'(msg_node); r.blk = int'(msg_blk);
                    r.d = fdata(int'(msg_node), int'(msg_blk));
                    rsp_q.push_back(r);
                end
            end
        end
    end

    task automatic issue(int k, int n, int b, logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_kind = 2'(k); req_node = 3'(n); req_blk = 2'(b); req_data = d;
        while (!req_ready) @(negedge clk);
        model_accept(k, n, b, d);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle(string tag);
        int t = 0;
        while ((exp_q.size() != 0 || !req_ready) && t < 300) begin
            @(negedge clk); t++;
        end
        chk(t < 300, tag, exp_q.size(), 0);
    endtask

    task automatic op(int k, int n, int b, logic [DW-1:0] d, string tag);
        issue(k, n, b, d);
        wait_idle(tag);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        ev_t bog;
        int unsigned s = 32'h1234_5678;
        for (int b = 0; b < BLOCKS; b++) begin m_st[b] = 0; m_sh[b] = 0; m_mem[b] = 0; end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
        chk(msg_valid == 0, "R1 quiet after reset", msg_valid, 0);

        op(0, 1, 0, 0, "R1 R2 read uncached");
        op(0, 3, 0, 0, "R2 second sharer");
        op(0, 5, 0, 0, "R2 third sharer");
        gen = 1; op(1, 3, 0, 0, "R3 write to shared");
        gen = 2; op(0, 2, 0, 0, "R5 read exclusive");
        gen = 3; op(1, 7, 0, 0, "R3 R5 both sharers invalidated");
        op(2, 7, 0, 16'h1234, "R7 owner write-back");
        op(0, 4, 0, 0, "R7 memory updated");
        op(2, 4, 0, 16'hDEAD, "R8 shared write-back ignored");
        op(1, 4, 0, 0, "R8 R4 sole sharer upgrade");
        op(2, 6, 0, 16'hBEEF, "R8 non-owner write-back ignored");
        gen = 4; op(0, 6, 0, 0, "R8 R5 fetch after ignored write-back");
        op(1, 0, 1, 0, "R4 write uncached");
        gen = 5; op(1, 5, 1, 0, "R6 write exclusive");

        // R9: engine holds while acknowledgements are withheld
        op(0, 1, 2, 0, "R2 setup");
        op(0, 2, 2, 0, "R2 setup");
        hold = 1;
        issue(1, 6, 2, 0);
        repeat (6) begin
            @(negedge clk);
            chk(req_ready == 0, "R9 stalled while acks pending", req_ready, 0);
        end
        chk(exp_q.size() == 1, "R9 data withheld", exp_q.size(), 1);
        bog.k = 0; bog.node = 1; bog.blk = 3; bog.d = '0; inj_q.push_back(bog);
        bog.k = 1; bog.node = 4; bog.blk = 2; bog.d = 16'h5555; inj_q.push_back(bog);
        repeat (4) @(negedge clk);
        chk(req_ready == 0, "R9 foreign responses ignored", req_ready, 0);
        chk(exp_q.size() == 1, "R9 no early reply", exp_q.size(), 1);
        hold = 0;
        wait_idle("R9 completes after acks");

        for (int i = 0; i < 40; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            gen = 6 + i;
            op(int'((s >> 16) % 3), int'((s >> 8) % 8), int'((s >> 4) % 4),
               16'(s >> 12), "R2 R3 R4 R5 R6 R7 R8 mixed");
        end

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule